// File: doc/BRIEF.md
# Response Ring Writer

This block takes responses coming back from audio codecs and stores them for software. Each response carries a 32-bit payload, a flag saying whether the codec sent it unprompted, and the 4-bit address of the codec that sent it. Ring responses are written into a circular buffer in system memory. Each entry takes 8 bytes: the payload word comes first, then a second word that describes the payload. The block writes through a plain request/acknowledge memory port.

The block has two other paths. While an immediate command is outstanding, the next response is kept in an immediate-response register and is not written to the ring. When ring transfers are switched off, responses are dropped.

An 8-bit slot pointer and a response counter track progress through the ring. An interrupt status bit rises after a programmed number of entries has been written, or when the command ring has drained. Clearing that bit resets the counter and sends a one-cycle request to the command engine to resume.

Top module: `rsp_ring_writer`

## Requirements
- R1: While `imm_busy` is 1, an accepted response is not written to memory. From the next cycle, `imm_resp` holds its payload, `imm_codec` holds its codec address, `imm_busy` is 0, `imm_valid` is 1, and `wr_ptr` is unchanged.
- R2: While `imm_busy` is 0 and `cfg_dma_en` is 0, an accepted response is dropped. No memory request is raised and `wr_ptr` is unchanged.
- R3: For a ring response, the pointer first advances by one modulo 256. The payload word is then written to `cfg_base + 8*wr_ptr`, followed by the descriptor word at `cfg_base + 8*wr_ptr + 4`. The payload write always comes first.
- R4: In the descriptor word, bit 4 is 1 for an unsolicited response and 0 for a solicited one. Bits 3:0 hold the codec address and all other bits are 0.
- R5: When a ring entry completes and `cfg_irq_en` is 1, `irq_sts` is set if the updated counter equals `cfg_count` or if `cmd_ring_empty` is 1. While `cfg_irq_en` is 0, a completed entry never sets `irq_sts`.
- R6: A pulse on `wp_reset` sets `wr_ptr` to 0, so the next ring entry goes to slot 1.
- R7: A pulse on `sts_clear` while `irq_sts` is 1 clears `irq_sts`, sets `rsp_cnt` to 0, and raises `cmd_kick` for exactly the next cycle. While `irq_sts` is 0, `sts_clear` has no effect and `cmd_kick` stays 0.
- R8: `rsp_cnt` increases by one for each completed ring entry and stops at `cfg_count`.
- R9: `mem_req` stays high with `mem_addr` and `mem_wdata` stable until `mem_ack` is seen. `rsp_ready` is 0 from acceptance until the descriptor word is acknowledged.
- R10: A pulse on `imm_start` sets `imm_busy` to 1 and `imm_valid` to 0 from the next cycle.
- R11: After reset, `wr_ptr`, `rsp_cnt`, `irq_sts`, `imm_busy`, `imm_valid`, `cmd_kick` and `mem_req` are 0, and `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Block can take a response |
| rsp_data | input | 32 | Response payload |
| rsp_unsol | input | 1 | 1 = unsolicited response |
| rsp_codec | input | 4 | Codec address of the responder |
| cfg_dma_en | input | 1 | Enables ring writes |
| cfg_irq_en | input | 1 | Enables setting of the status bit |
| cfg_base | input | ADDR_W | Ring base byte address, 8-byte aligned |
| cfg_count | input | PTR_W | Entry count threshold |
| cmd_ring_empty | input | 1 | Command ring has no pending commands |
| wp_reset | input | 1 | Pulse: clear the slot pointer |
| sts_clear | input | 1 | Pulse: write-one-to-clear of the status bit |
| imm_start | input | 1 | Pulse: an immediate command was issued |
| imm_busy | output | 1 | Immediate command outstanding |
| imm_valid | output | 1 | Immediate response captured |
| imm_codec | output | 4 | Codec address of the captured response |
| imm_resp | output | 32 | Captured immediate response |
| wr_ptr | output | PTR_W | Last slot written |
| rsp_cnt | output | PTR_W | Entries since the last clear |
| irq_sts | output | 1 | Response interrupt status |
| cmd_kick | output | 1 | One-cycle restart request to the command engine |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Write accepted |

## Verification
The assertions take three things for granted:
- `cfg_base` is a multiple of 8, so a payload address always has bit 2 clear and its descriptor sits exactly 4 bytes higher.
- `mem_ack` only arrives while `mem_req` is high.
- `wp_reset` is not pulsed in the same cycle that a ring response is accepted.

The stimulus keeps to these rules. It holds the ring base at an 8-byte boundary and answers memory requests with a delay of zero to several cycles. It issues pointer resets and status clears only between responses, while the block is idle.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

    localparam int RSP_DATA_W  = 32;
    localparam int CODEC_W     = 4;
    localparam int ENTRY_SHIFT = 3;   // 8-byte ring entries
    localparam int DESC_OFS    = 4;   // descriptor word offset inside an entry
    localparam int UNSOL_BIT   = 4;   // position of the unsolicited flag

    typedef struct packed {
        logic [RSP_DATA_W-1:0] data;
        logic                  unsol;
        logic [CODEC_W-1:0]    codec;
    } rsp_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DATA  = 2'd1,
        SEQ_DESC  = 2'd2
    } seq_state_e;

    function automatic logic [RSP_DATA_W-1:0] make_desc(input rsp_t r);
        logic [RSP_DATA_W-1:0] w;
        w = '0;
        w[UNSOL_BIT]       = r.unsol;
        w[CODEC_W-1:0]     = r.codec;
        return w;
    endfunction

endpackage

// File: rtl/rrw_imm_capture.sv
module rrw_imm_capture
    import rrw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  take,
    input  rsp_t                  rsp,
    output logic                  busy,
    output logic                  valid,
    output logic [CODEC_W-1:0]    codec,
    output logic [RSP_DATA_W-1:0] resp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            valid <= 1'b0;
            codec <= '0;
            resp  <= '0;
        end else if (take) begin
            busy  <= 1'b0;
            valid <= 1'b1;
            codec <= rsp.codec;
            resp  <= rsp.data;
        end else if (start) begin
            busy  <= 1'b1;
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/rrw_ring_ptr.sv
module rrw_ring_ptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] slot
);

    logic [PTR_W-1:0] base_ptr;
    logic [PTR_W-1:0] next_ptr;

    always_comb begin
        base_ptr = clear ? '0 : wr_ptr;
        next_ptr = base_ptr + PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            slot   <= '0;
        end else begin
            if (advance) begin
                wr_ptr <= next_ptr;
                slot   <= next_ptr;
            end else begin
                wr_ptr <= base_ptr;
            end
        end
    end

endmodule

// File: rtl/rrw_mem_seq.sv
module rrw_mem_seq
    import rrw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  rsp_t                  entry_in,
    input  logic [PTR_W-1:0]      slot,
    input  logic [ADDR_W-1:0]     base,
    input  logic                  mem_ack,
    output logic                  idle,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [RSP_DATA_W-1:0] mem_wdata,
    output logic                  done
);

    localparam int OFS_W = PTR_W + ENTRY_SHIFT;

    seq_state_e        state;
    rsp_t              entry_q;
    logic [ADDR_W-1:0] entry_addr;

    always_comb begin
        entry_addr = base + ADDR_W'({slot, {ENTRY_SHIFT{1'b0}}});
        idle       = (state == SEQ_IDLE);
        mem_req    = (state != SEQ_IDLE);
        done       = (state == SEQ_DESC) && mem_ack;
        if (state == SEQ_DESC) begin
            mem_addr  = entry_addr + ADDR_W'(DESC_OFS);
            mem_wdata = make_desc(entry_q);
        end else begin
            mem_addr  = entry_addr;
            mem_wdata = entry_q.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            entry_q <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        entry_q <= entry_in;
                        state   <= SEQ_DATA;
                    end
                end
                SEQ_DATA: if (mem_ack) state <= SEQ_DESC;
                SEQ_DESC: if (mem_ack) state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    logic [OFS_W-1:0] unused_ofs;
    assign unused_ofs = '0;

endmodule

// File: rtl/rrw_int_ctrl.sv
module rrw_int_ctrl #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic             cmd_empty,
    input  logic             irq_en,
    input  logic [PTR_W-1:0] threshold,
    input  logic             sts_clear,
    output logic [PTR_W-1:0] cnt,
    output logic             irq_sts,
    output logic             cmd_kick
);

    logic             clr_hit;
    logic [PTR_W-1:0] cnt_base;
    logic [PTR_W-1:0] cnt_inc;
    logic             irq_base;
    logic             raise;

    always_comb begin
        clr_hit  = sts_clear && irq_sts;
        cnt_base = clr_hit ? '0 : cnt;
        irq_base = clr_hit ? 1'b0 : irq_sts;
        cnt_inc  = (cnt_base >= threshold) ? cnt_base : cnt_base + PTR_W'(1);
        raise    = done && irq_en && ((cnt_inc == threshold) || cmd_empty);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            irq_sts  <= 1'b0;
            cmd_kick <= 1'b0;
        end else begin
            cnt      <= done ? cnt_inc : cnt_base;
            irq_sts  <= irq_base || raise;
            cmd_kick <= clr_hit;
        end
    end

endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
    import rrw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_data,
    input  logic              rsp_unsol,
    input  logic [3:0]        rsp_codec,
    input  logic              cfg_dma_en,
    input  logic              cfg_irq_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PTR_W-1:0]  cfg_count,
    input  logic              cmd_ring_empty,
    input  logic              wp_reset,
    input  logic              sts_clear,
    input  logic              imm_start,
    output logic              imm_busy,
    output logic              imm_valid,
    output logic [3:0]        imm_codec,
    output logic [31:0]       imm_resp,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rsp_cnt,
    output logic              irq_sts,
    output logic              cmd_kick,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack
);

    rsp_t             rsp_in;
    logic             fire;
    logic             take_imm;
    logic             to_ring;
    logic             seq_idle;
    logic             entry_done;
    logic [PTR_W-1:0] slot;

    always_comb begin
        rsp_in.data  = rsp_data;
        rsp_in.unsol = rsp_unsol;
        rsp_in.codec = rsp_codec;
        rsp_ready    = seq_idle;
        fire         = rsp_valid && seq_idle;
        take_imm     = fire && imm_busy;
        to_ring      = fire && !imm_busy && cfg_dma_en;
    end

    rrw_imm_capture u_imm (
        .clk   (clk),
        .rst   (rst),
        .start (imm_start),
        .take  (take_imm),
        .rsp   (rsp_in),
        .busy  (imm_busy),
        .valid (imm_valid),
        .codec (imm_codec),
        .resp  (imm_resp)
    );

    rrw_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clear   (wp_reset),
        .advance (to_ring),
        .wr_ptr  (wr_ptr),
        .slot    (slot)
    );

    rrw_mem_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (to_ring),
        .entry_in  (rsp_in),
        .slot      (slot),
        .base      (cfg_base),
        .mem_ack   (mem_ack),
        .idle      (seq_idle),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (entry_done)
    );

    rrw_int_ctrl #(.PTR_W(PTR_W)) u_int (
        .clk       (clk),
        .rst       (rst),
        .done      (entry_done),
        .cmd_empty (cmd_ring_empty),
        .irq_en    (cfg_irq_en),
        .threshold (cfg_count),
        .sts_clear (sts_clear),
        .cnt       (rsp_cnt),
        .irq_sts   (irq_sts),
        .cmd_kick  (cmd_kick)
    );

endmodule

// File: rtl/rrw_checks.sv
module rrw_checks #(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [3:0]        rsp_codec,
    input logic              cfg_dma_en,
    input logic              wp_reset,
    input logic              sts_clear,
    input logic              imm_busy,
    input logic              imm_valid,
    input logic [3:0]        imm_codec,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              irq_sts,
    input logic              cmd_kick,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack
);

    p_imm_capture_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && imm_busy
        |=> !imm_busy && imm_valid && imm_codec == $past(rsp_codec) && !mem_req);

    p_drop_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && !imm_busy && !cfg_dma_en
        |=> !mem_req && wr_ptr == $past(wr_ptr));

    p_desc_follows_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && !mem_addr[2]
        |=> mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4));

    p_ptr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        wp_reset && !(rsp_valid && rsp_ready && !imm_busy && cfg_dma_en)
        |=> wr_ptr == '0);

    p_kick_r7: assert property (@(posedge clk) disable iff (rst)
        sts_clear && irq_sts |=> cmd_kick);

    p_no_kick_r7: assert property (@(posedge clk) disable iff (rst)
        !(sts_clear && irq_sts) |=> !cmd_kick);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack
        |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

    p_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !rsp_ready);

endmodule

bind rsp_ring_writer rrw_checks #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rrw_checks (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_codec  (rsp_codec),
    .cfg_dma_en (cfg_dma_en),
    .wp_reset   (wp_reset),
    .sts_clear  (sts_clear),
    .imm_busy   (imm_busy),
    .imm_valid  (imm_valid),
    .imm_codec  (imm_codec),
    .wr_ptr     (wr_ptr),
    .irq_sts    (irq_sts),
    .cmd_kick   (cmd_kick),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/test_rsp_ring_writer.sv
module test_rsp_ring_writer;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int PTR_W      = 8;
    localparam logic [ADDR_W-1:0] BASE = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst;
    logic              rsp_valid, rsp_ready, rsp_unsol;
    logic [31:0]       rsp_data;
    logic [3:0]        rsp_codec;
    logic              cfg_dma_en, cfg_irq_en;
    logic [ADDR_W-1:0] cfg_base;
    logic [PTR_W-1:0]  cfg_count;
    logic              cmd_ring_empty, wp_reset, sts_clear, imm_start;
    logic              imm_busy, imm_valid;
    logic [3:0]        imm_codec;
    logic [31:0]       imm_resp;
    logic [PTR_W-1:0]  wr_ptr, rsp_cnt;
    logic              irq_sts, cmd_kick, mem_req, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;

    int          n_chk = 0;
    int          n_bad = 0;
    int          lat   = 1;
    logic [63:0] exp_q[$];
    logic [PTR_W-1:0] model_wp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsp_ring_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_rsp_ring_writer (
        .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_unsol(rsp_unsol), .rsp_codec(rsp_codec),
        .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .cmd_ring_empty(cmd_ring_empty),
        .wp_reset(wp_reset), .sts_clear(sts_clear), .imm_start(imm_start),
        .imm_busy(imm_busy), .imm_valid(imm_valid), .imm_codec(imm_codec),
        .imm_resp(imm_resp), .wr_ptr(wr_ptr), .rsp_cnt(rsp_cnt),
        .irq_sts(irq_sts), .cmd_kick(cmd_kick), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Memory responder and scoreboard monitor: R3 order/addresses, R4 descriptor
    initial begin
        int w = 0;
        mem_ack = 1'b0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (w >= lat) begin
                    logic [63:0] e;
                    mem_ack = 1'b1;
                    w = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected write", {mem_addr, mem_wdata}, 64'h0);
                    end else begin
                        e = exp_q.pop_front();
                        check(mem_addr == e[63:32], "R3", "write address", 64'(mem_addr), 64'(e[63:32]));
                        check(mem_wdata == e[31:0], "R4", "write data", 64'(mem_wdata), 64'(e[31:0]));
                    end
                end else begin
                    w++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    function automatic logic [31:0] desc(input logic unsol, input logic [3:0] codec);
        return {27'b0, unsol, codec};
    endfunction

    task automatic send(input logic [31:0] d, input logic u, input logic [3:0] c,
                        input bit to_ring);
        logic [ADDR_W-1:0] a;
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        if (to_ring) begin
            model_wp = model_wp + 1'b1;
            a = BASE + ADDR_W'(model_wp) * 8;
            exp_q.push_back({a, d});
            exp_q.push_back({a + 32'd4, desc(u, c)});
        end
        rsp_valid = 1'b1; rsp_data = d; rsp_unsol = u; rsp_codec = c;
        @(negedge clk);
        rsp_valid = 1'b0;
        while (!rsp_ready) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); sts_clear = 1'b1;
        @(negedge clk); sts_clear = 1'b0;
    endtask

    initial begin
        rst = 1'b1; rsp_valid = 0; rsp_data = 0; rsp_unsol = 0; rsp_codec = 0;
        cfg_dma_en = 0; cfg_irq_en = 0; cfg_base = BASE; cfg_count = 0;
        cmd_ring_empty = 0; wp_reset = 0; sts_clear = 0; imm_start = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(wr_ptr == 0 && rsp_cnt == 0, "R11", "ptr/cnt", {wr_ptr, rsp_cnt}, 0);
        check(!irq_sts && !imm_busy && !imm_valid && !cmd_kick && !mem_req, "R11", "flags",
              {irq_sts, imm_busy, imm_valid, cmd_kick, mem_req}, 0);
        check(rsp_ready, "R11", "ready", rsp_ready, 1);

        // R10 immediate start, then R1 capture even with ring enabled
        cfg_dma_en = 1;
        @(negedge clk); imm_start = 1; @(negedge clk); imm_start = 0;
        check(imm_busy && !imm_valid, "R10", "busy/valid", {imm_busy, imm_valid}, 2'b10);
        send(32'hCAFE_0001, 1'b0, 4'd5, 0);
        check(!imm_busy && imm_valid, "R1", "busy/valid", {imm_busy, imm_valid}, 2'b01);
        check(imm_codec == 4'd5 && imm_resp == 32'hCAFE_0001, "R1", "codec/resp",
              {imm_codec, imm_resp}, {4'd5, 32'hCAFE_0001});
        check(wr_ptr == 0 && exp_q.size() == 0, "R1", "ring untouched", wr_ptr, 0);

        // R2 drop
        cfg_dma_en = 0;
        send(32'h1111_2222, 1'b1, 4'd3, 0);
        check(wr_ptr == 0 && !mem_req, "R2", "ptr after drop", wr_ptr, 0);
        check(imm_resp == 32'hCAFE_0001, "R2", "imm unchanged", imm_resp, 32'hCAFE_0001);

        // R3/R4 ring writes with mixed flags
        cfg_dma_en = 1; lat = 1;
        send(32'hA0A0_0001, 1'b0, 4'd2, 1);
        send(32'hA0A0_0002, 1'b1, 4'd15, 1);
        lat = 2;
        send(32'hA0A0_0003, 1'b1, 4'd0, 1);
        check(wr_ptr == 3, "R3", "ptr after 3", wr_ptr, 3);
        check(rsp_cnt == 0 && !irq_sts, "R8", "cnt saturates at 0", rsp_cnt, 0);

        // R8/R5 threshold path
        cfg_count = 3; cfg_irq_en = 1; lat = 0;
        send(32'hB0, 0, 4'd1, 1);
        send(32'hB1, 0, 4'd1, 1);
        check(rsp_cnt == 2 && !irq_sts, "R5", "below threshold", {rsp_cnt, irq_sts}, {8'd2, 1'b0});
        send(32'hB2, 0, 4'd1, 1);
        check(rsp_cnt == 3 && irq_sts, "R5", "at threshold", {rsp_cnt, irq_sts}, {8'd3, 1'b1});
        send(32'hB3, 0, 4'd1, 1);
        check(rsp_cnt == 3, "R8", "saturate", rsp_cnt, 3);

        // R7 clear with status set, then with status clear
        pulse_clear();
        check(cmd_kick && !irq_sts && rsp_cnt == 0, "R7", "kick/clear",
              {cmd_kick, irq_sts, rsp_cnt}, {1'b1, 1'b0, 8'd0});
        @(negedge clk);
        check(!cmd_kick, "R7", "kick one cycle", cmd_kick, 0);
        pulse_clear();
        check(!cmd_kick, "R7", "no kick when idle", cmd_kick, 0);

        // R5 drained-command-ring path, and disabled enable
        cfg_count = 10; cmd_ring_empty = 1;
        send(32'hC0, 1, 4'd7, 1);
        check(irq_sts && rsp_cnt == 1, "R5", "empty ring raise", {irq_sts, rsp_cnt}, {1'b1, 8'd1});
        pulse_clear();
        cfg_irq_en = 0;
        send(32'hC1, 1, 4'd7, 1);
        check(!irq_sts, "R5", "enable off", irq_sts, 0);
        cmd_ring_empty = 0;

        // R6 pointer reset
        @(negedge clk); wp_reset = 1; @(negedge clk); wp_reset = 0;
        check(wr_ptr == 0, "R6", "cleared", wr_ptr, 0);
        model_wp = '0;
        send(32'hD0, 0, 4'd9, 1);
        check(wr_ptr == 1, "R6", "next slot 1", wr_ptr, 1);

        // R9 handshake hold
        lat = 4;
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        model_wp = model_wp + 1'b1;
        exp_q.push_back({BASE + 32'd16, 32'hE0});
        exp_q.push_back({BASE + 32'd20, desc(1'b0, 4'd4)});
        rsp_valid = 1; rsp_data = 32'hE0; rsp_unsol = 0; rsp_codec = 4'd4;
        @(negedge clk); rsp_valid = 0;
        check(!rsp_ready && mem_req, "R9", "busy during write", {rsp_ready, mem_req}, 2'b01);
        @(negedge clk);
        check(mem_addr == BASE + 32'd16 && !rsp_ready, "R9", "held addr", mem_addr, BASE + 32'd16);
        while (!rsp_ready) @(negedge clk);

        // R3 wrap-around of the slot pointer
        lat = 0;
        for (int i = 0; i < 254; i++) send(32'hF000_0000 + i, i[0], i[3:0], 1);
        check(wr_ptr == 0, "R3", "wrap to slot 0", wr_ptr, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all writes seen", exp_q.size(), 0);
        finish_run();
    end

endmodule